// File: doc/BRIEF.md
# 802.11 Data Header Address Selector

This block chooses the four 48-bit address fields of an 802.11 data header for each MSDU that a transmit encapsulation engine handles. It takes the programmed per-peer addresses (peer A, peer B and the transmitter address) and the frame's own destination (DA) and source (SA) addresses. From these it produces address 1 (receiver), address 2 (transmitter), address 3 and address 4, plus a flag that marks a four-address frame.

The receiver address is decided once per MPDU, on the MSDU that carries the first-of-MPDU marker. Later MSDUs of the same aggregate reuse that decision, whatever their own steering flag says. Address 3 and address 4 come from a 3-bit mixing code. The code can take either programmed peer address for each field, or it can take DA and SA. Out-of-range codes are flagged and treated as the DA/SA choice.

The block has no back-pressure. An MSDU is presented by a one-cycle `msdu_start` strobe and is always accepted. The results appear one clock later and stay unchanged until the next strobe. The downstream header builder samples them whenever it needs them.

Top module: `mpdu_addr_select`

## Requirements
- R1: All outputs are registered. They change only in the clock after a cycle with `msdu_start` high, and otherwise hold their values, except `sel_illegal`, which returns to 0.
- R2: On an MSDU with `mpdu_first` high, the block records `use_b`. Address 1 becomes `peer_b` when `use_b` is 1 and `da` when it is 0.
- R3: On an MSDU with `mpdu_first` low, `use_b` has no effect. Address 1 follows the decision recorded at the last first-of-MPDU MSDU, applied to the current `peer_b` or `da`.
- R4: `four_addr` equals `user_4a` OR `frame_4a` of the accepted MSDU.
- R5: `sel_code` (3 bits) for codes 0 to 3: code 0 gives AD3=A, AD4=A; code 1 gives AD3=A, AD4=B; code 2 gives AD3=B, AD4=A; code 3 gives AD3=B, AD4=B (A=`peer_a`, B=`peer_b`).
- R6: Code 4 gives AD3=`da`, AD4=`sa`. Codes 5, 6 and 7 produce the same addresses as code 4.
- R7: `sel_illegal` is 1 for exactly one cycle after an MSDU whose code is 5, 6 or 7. It is 0 after an MSDU with code 0 to 4.
- R8: Address 4 is all zeros whenever `four_addr` is 0.
- R9: Address 2 equals the `ta` input of the accepted MSDU.
- R10: A synchronous active-high `rst` clears all four addresses, `four_addr`, `sel_illegal` and the recorded receiver decision, which then selects `da`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msdu_start | input | 1 | One-cycle strobe presenting an MSDU |
| mpdu_first | input | 1 | MSDU is the first of its MPDU |
| use_b | input | 1 | Steer receiver address to peer B (first MSDU only) |
| user_4a | input | 1 | All frames of this user are four-address |
| frame_4a | input | 1 | This frame is four-address |
| sel_code | input | 3 | AD3/AD4 mixing code |
| peer_a | input | 48 | Programmed peer address A |
| peer_b | input | 48 | Programmed peer address B |
| ta | input | 48 | Programmed transmitter address |
| da | input | 48 | Frame destination address |
| sa | input | 48 | Frame source address |
| ad1 | output | 48 | Receiver address |
| ad2 | output | 48 | Transmitter address |
| ad3 | output | 48 | Address 3 |
| ad4 | output | 48 | Address 4, zero unless four-address |
| four_addr | output | 1 | Frame uses four addresses |
| sel_illegal | output | 1 | Previous MSDU carried an illegal code |

## Verification
The assertions check on every cycle that the outputs hold between strobes and that the illegal flag is a single-cycle pulse. They also check that address 4 stays zero for three-address frames, that address 2 and the four-address flag follow the accepted MSDU, and that the first-of-MPDU receiver choice and the DA/SA fallback hold. The behaviour that depends on history needs the bench's scenarios. In those scenarios, a later MSDU of an aggregate ignores its own steering bit and keeps the earlier decision. The decision is also shown to survive idle gaps and to be cleared by reset.

// File: rtl/addr_sel_pkg.sv
package addr_sel_pkg;
  localparam int ADDR_W = 48;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    MIX_AA = 3'd0,
    MIX_AB = 3'd1,
    MIX_BA = 3'd2,
    MIX_BB = 3'd3,
    MIX_DS = 3'd4
  } mix_code_e;

  localparam logic [CODE_W-1:0] LAST_LEGAL = CODE_W'(MIX_DS);
endpackage

// File: rtl/ra_hold.sv
module ra_hold #(
  parameter int AW = addr_sel_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          first,
  input  logic          steer_b,
  input  logic [AW-1:0] addr_b,
  input  logic [AW-1:0] addr_da,
  output logic [AW-1:0] ra
);
  logic held_b;
  logic eff_b;

  // A new steering decision is taken only on the first MSDU of an MPDU.
  assign eff_b = (take && first) ? steer_b : held_b;
  assign ra    = eff_b ? addr_b : addr_da;

  always_ff @(posedge clk) begin
    if (rst)                 held_b <= 1'b0;
    else if (take && first)  held_b <= steer_b;
  end
endmodule

// File: rtl/ad34_mux.sv
module ad34_mux
  import addr_sel_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] code,
  input  logic          four,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [AW-1:0] addr_da,
  input  logic [AW-1:0] addr_sa,
  output logic [AW-1:0] ad3,
  output logic [AW-1:0] ad4,
  output logic          bad
);
  logic [AW-1:0] ad4_raw;

  assign bad = (code > LAST_LEGAL);

  always_comb begin
    unique case (code)
      CW'(MIX_AA): begin ad3 = addr_a;  ad4_raw = addr_a;  end
      CW'(MIX_AB): begin ad3 = addr_a;  ad4_raw = addr_b;  end
      CW'(MIX_BA): begin ad3 = addr_b;  ad4_raw = addr_a;  end
      CW'(MIX_BB): begin ad3 = addr_b;  ad4_raw = addr_b;  end
      default:     begin ad3 = addr_da; ad4_raw = addr_sa; end
    endcase
  end

  assign ad4 = four ? ad4_raw : '0;
endmodule

// File: rtl/mpdu_addr_select.sv
module mpdu_addr_select
  import addr_sel_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msdu_start,
  input  logic          mpdu_first,
  input  logic          use_b,
  input  logic          user_4a,
  input  logic          frame_4a,
  input  logic [CW-1:0] sel_code,
  input  logic [AW-1:0] peer_a,
  input  logic [AW-1:0] peer_b,
  input  logic [AW-1:0] ta,
  input  logic [AW-1:0] da,
  input  logic [AW-1:0] sa,
  output logic [AW-1:0] ad1,
  output logic [AW-1:0] ad2,
  output logic [AW-1:0] ad3,
  output logic [AW-1:0] ad4,
  output logic          four_addr,
  output logic          sel_illegal
);
  logic [AW-1:0] ra_n, ad3_n, ad4_n;
  logic          four_n, bad_n;

  assign four_n = user_4a | frame_4a;

  ra_hold #(.AW(AW)) u_ra (
    .clk(clk), .rst(rst), .take(msdu_start), .first(mpdu_first),
    .steer_b(use_b), .addr_b(peer_b), .addr_da(da), .ra(ra_n)
  );

  ad34_mux #(.AW(AW), .CW(CW)) u_mix (
    .code(sel_code), .four(four_n), .addr_a(peer_a), .addr_b(peer_b),
    .addr_da(da), .addr_sa(sa), .ad3(ad3_n), .ad4(ad4_n), .bad(bad_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ad1 <= '0; ad2 <= '0; ad3 <= '0; ad4 <= '0;
      four_addr   <= 1'b0;
      sel_illegal <= 1'b0;
    end else begin
      sel_illegal <= msdu_start & bad_n;
      if (msdu_start) begin
        ad1       <= ra_n;
        ad2       <= ta;
        ad3       <= ad3_n;
        ad4       <= ad4_n;
        four_addr <= four_n;
      end
    end
  end
endmodule

// File: rtl/mpdu_addr_select_chk.sv
module mpdu_addr_select_chk #(
  parameter int AW = 48,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          msdu_start,
  input logic          mpdu_first,
  input logic          use_b,
  input logic          user_4a,
  input logic          frame_4a,
  input logic [CW-1:0] sel_code,
  input logic [AW-1:0] peer_b,
  input logic [AW-1:0] ta,
  input logic [AW-1:0] da,
  input logic [AW-1:0] sa,
  input logic [AW-1:0] ad1,
  input logic [AW-1:0] ad2,
  input logic [AW-1:0] ad3,
  input logic [AW-1:0] ad4,
  input logic          four_addr,
  input logic          sel_illegal
);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !msdu_start |=> $stable(ad1) && $stable(ad2) && $stable(ad3) && $stable(ad4) && $stable(four_addr));

  p_ra_first_r2: assert property (@(posedge clk) disable iff (rst)
    msdu_start && mpdu_first |=> ad1 == ($past(use_b) ? $past(peer_b) : $past(da)));

  p_four_r4: assert property (@(posedge clk) disable iff (rst)
    msdu_start |=> four_addr == ($past(user_4a) | $past(frame_4a)));

  p_ds_fallback_r6: assert property (@(posedge clk) disable iff (rst)
    msdu_start && sel_code >= CW'(4) |=> ad3 == $past(da) && (!four_addr || ad4 == $past(sa)));

  p_illegal_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !msdu_start |=> !sel_illegal);

  p_illegal_legal_r7: assert property (@(posedge clk) disable iff (rst)
    msdu_start && sel_code <= CW'(4) |=> !sel_illegal);

  p_ad4_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !four_addr |-> ad4 == '0);

  p_ta_r9: assert property (@(posedge clk) disable iff (rst)
    msdu_start |=> ad2 == $past(ta));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> ad1 == '0 && ad2 == '0 && !four_addr && !sel_illegal);
endmodule

bind mpdu_addr_select mpdu_addr_select_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .msdu_start(msdu_start), .mpdu_first(mpdu_first),
  .use_b(use_b), .user_4a(user_4a), .frame_4a(frame_4a), .sel_code(sel_code),
  .peer_b(peer_b), .ta(ta), .da(da), .sa(sa),
  .ad1(ad1), .ad2(ad2), .ad3(ad3), .ad4(ad4),
  .four_addr(four_addr), .sel_illegal(sel_illegal)
);

// File: tb/sim_mpdu_addr_select.sv
module sim_mpdu_addr_select;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst = 1'b1;
  logic        msdu_start = 0, mpdu_first = 0, use_b = 0, user_4a = 0, frame_4a = 0;
  logic [2:0]  sel_code = 0;
  logic [47:0] peer_a = 0, peer_b = 0, ta = 0, da = 0, sa = 0;
  logic [47:0] ad1, ad2, ad3, ad4;
  logic        four_addr, sel_illegal;

  mpdu_addr_select u0 (
    .clk(clk), .rst(rst), .msdu_start(msdu_start), .mpdu_first(mpdu_first),
    .use_b(use_b), .user_4a(user_4a), .frame_4a(frame_4a), .sel_code(sel_code),
    .peer_a(peer_a), .peer_b(peer_b), .ta(ta), .da(da), .sa(sa),
    .ad1(ad1), .ad2(ad2), .ad3(ad3), .ad4(ad4),
    .four_addr(four_addr), .sel_illegal(sel_illegal)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // Behavioural reference state
  logic [47:0] m1 = 0, m2 = 0, m3 = 0, m4 = 0;
  logic        m4a = 0, mill = 0, msteer = 0, started = 0;
  logic        l_rst = 0, l_start = 0, l_first = 0;
  logic [2:0]  l_code = 0;

  always @(posedge clk) begin
    l_rst = rst; l_start = msdu_start; l_first = mpdu_first; l_code = sel_code;
    started = 1;
    if (rst) begin
      m1 = 0; m2 = 0; m3 = 0; m4 = 0; m4a = 0; mill = 0; msteer = 0;
    end else begin
      mill = msdu_start && (sel_code >= 5);
      if (msdu_start) begin
        if (mpdu_first) msteer = use_b;
        m1  = msteer ? peer_b : da;
        m2  = ta;
        m4a = user_4a || frame_4a;
        case (sel_code)
          0: begin m3 = peer_a; m4 = peer_a; end
          1: begin m3 = peer_a; m4 = peer_b; end
          2: begin m3 = peer_b; m4 = peer_a; end
          3: begin m3 = peer_b; m4 = peer_b; end
          default: begin m3 = da; m4 = sa; end
        endcase
        if (!m4a) m4 = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (l_rst) begin
        chk("R10 ad1", ad1, m1); chk("R10 ad2", ad2, m2); chk("R10 ad3", ad3, m3);
        chk("R10 ad4", ad4, m4); chk("R10 four", {47'd0, four_addr}, {47'd0, m4a});
        chk("R10 illegal", {47'd0, sel_illegal}, {47'd0, mill});
      end else if (!l_start) begin
        chk("R1 hold ad1", ad1, m1); chk("R1 hold ad2", ad2, m2);
        chk("R1 hold ad3", ad3, m3); chk("R1 hold ad4", ad4, m4);
        chk("R1 hold four", {47'd0, four_addr}, {47'd0, m4a});
        chk("R7 illegal low", {47'd0, sel_illegal}, {47'd0, mill});
      end else begin
        chk(l_first ? "R2 ad1" : "R3 ad1", ad1, m1);
        chk("R9 ad2", ad2, m2);
        chk(l_code >= 4 ? "R6 ad3" : "R5 ad3", ad3, m3);
        chk(!m4a ? "R8 ad4" : (l_code >= 4 ? "R6 ad4" : "R5 ad4"), ad4, m4);
        chk("R4 four", {47'd0, four_addr}, {47'd0, m4a});
        chk("R7 illegal", {47'd0, sel_illegal}, {47'd0, mill});
      end
    end
  end

  task automatic msdu(input logic f, input logic ub, input logic u4, input logic f4,
                      input logic [2:0] c);
    @(negedge clk);
    msdu_start = 1; mpdu_first = f; use_b = ub; user_4a = u4; frame_4a = f4; sel_code = c;
    da = {16'hDA00, $urandom}; sa = {16'h5A00, $urandom};
    @(negedge clk);
    msdu_start = 0; use_b = ~ub;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    peer_a = 48'hAAAA_0000_0001; peer_b = 48'hBBBB_0000_0002; ta = 48'h7A7A_0000_0003;
    repeat (3) @(negedge clk);
    rst = 0;
    // R2/R3: first MSDU steers to B, later ones with use_b low keep B
    msdu(1, 1, 0, 1, 0); msdu(0, 0, 0, 1, 1); idle(3); msdu(0, 0, 1, 0, 2);
    // new MPDU steers to DA; later MSDU with use_b high is ignored
    msdu(1, 0, 0, 0, 3); msdu(0, 1, 1, 1, 4);
    // R5/R6/R7: every code, four-address on and off
    for (int c = 0; c < 8; c++) begin
      msdu(c[0], c[1], 1, 0, 3'(c));
      msdu(0, 0, 0, 0, 3'(c));
      idle(1);
    end
    // back-to-back strobes with illegal codes
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      msdu_start = 1; mpdu_first = k[0]; use_b = k[1]; sel_code = 3'(5 + k % 3);
      user_4a = 0; frame_4a = 1; da = {32'hD0D0_0000, 16'(k)}; sa = {32'h5050_0000, 16'(k)};
      @(negedge clk);
    end
    msdu_start = 0;
    idle(2);
    // R10: reset in the middle clears steering
    msdu(1, 1, 1, 1, 1);
    rst = 1; idle(2); rst = 0;
    msdu(0, 1, 0, 1, 2);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      peer_a = {$urandom, 16'(i)}; peer_b = {16'(i), $urandom}; ta = {$urandom, 16'h7A};
      if ($urandom % 3 == 0) idle(1);
      else msdu(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    end
    idle(3);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule